// File: doc/BRIEF.md
# Conversion-Done DMA Request Generator

This block turns the end of a conversion chain into a DMA request, one request line per trigger group. Eight groups are served by default. When a group reports that its chain has finished and the group's DMA enable is on, the block records a pending request for that group and drives the group's request line toward the DMA controller.

How a pending request goes away depends on a single mode bit shared by all groups. In latched mode the request stays up until the DMA controller has acknowledged it and the source's own request level has also dropped, in either order. In pulsed mode the acknowledge alone removes it. Software can also remove pending requests by writing ones to the status field of the control word. Writing zeros there has no effect, so software can change the enables without touching pending requests. Only the crossbar trigger groups feed this block. The touch-controller triggers have no path to a request.

Top module: `conv_dma_req`

## Requirements
- R1: After reset the control word reads 0 and every request line is 0.
- R2: A chain-done pulse on group g with enable bit g set makes status bit g and request line g read 1 on the cycle after the pulse. A pulse on a group whose enable is 0 sets nothing.
- R3: In latched mode (control bit 29 = 0), a pending request clears only once an acknowledge has been seen for the group and that group's source request input is low. The acknowledge may come before or while the source falls.
- R4: In pulsed mode (control bit 29 = 1), an acknowledge clears the pending request on the next cycle whatever the source request level is.
- R5: Control word layout: enables at bits 7..0 (bit g for group g), request status at bits 23..16 (bit 16+g for group g), mode at bit 29, all other bits read 0. A write stores the enables and the mode. Writing 1 to status bit 16+g clears it. Writing 0 there leaves it unchanged.
- R6: When a chain-done event that would set a group arrives in the same cycle as a clear of that group (by write or by acknowledge), the group ends up pending.
- R7: Clearing a group's enable bit forces its request line to 0 from the next cycle and keeps its status bit. Setting the enable again brings the request line back.
- R8: Groups are independent: an event, acknowledge or clear on one group changes no other group's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_i | input | NGRP | Chain-done pulse, one bit per group |
| src_req_i | input | NGRP | Source request level, one bit per group |
| ack_i | input | NGRP | DMA acknowledge, one bit per group |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | DW | Control word write data |
| ctrl_rdata_o | output | DW | Control word read value |
| dma_req_o | output | NGRP | DMA request, one line per group |

## Verification
The hardest situation to reach is the latched removal, where the acknowledge arrives while the source request is still high and the source only drops cycles later. The block has to remember the early acknowledge. The stimulus holds the source high, pulses the acknowledge once, and checks that the request stays up over idle cycles. It then lowers the source and checks that the request falls with no further acknowledge. Collisions are also forced: a done pulse is placed in the same cycle as a write-one clear, and in the same cycle as an acknowledge, to show that the set wins.

// File: rtl/conv_dma_req.sv
module conv_dma_req #(
  parameter int NGRP     = 8,
  parameter int DW       = 32,
  parameter int STAT_LSB = 16,
  parameter int MODE_BIT = 29
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGRP-1:0] done_i,
  input  logic [NGRP-1:0] src_req_i,
  input  logic [NGRP-1:0] ack_i,
  input  logic            ctrl_we_i,
  input  logic [DW-1:0]   ctrl_wdata_i,
  output logic [DW-1:0]   ctrl_rdata_o,
  output logic [NGRP-1:0] dma_req_o
);
  localparam logic [DW-1:0] GRP_ONES  = DW'((64'd1 << NGRP) - 64'd1);
  localparam logic [DW-1:0] USED_MASK = GRP_ONES | (GRP_ONES << STAT_LSB) | (DW'(1) << MODE_BIT);

  logic [NGRP-1:0] en_q, stat_q, ackseen_q;
  logic            mode_q;
  logic [NGRP-1:0] set_ev, w1c, ack_clr, clr;
  logic            unused_wbits;

  assign w1c     = ctrl_we_i ? ctrl_wdata_i[STAT_LSB +: NGRP] : '0;
  assign set_ev  = done_i & en_q;
  assign ack_clr = mode_q ? ack_i : ((ack_i | ackseen_q) & ~src_req_i);
  assign clr     = w1c | ack_clr;
  assign unused_wbits = ^(ctrl_wdata_i & ~USED_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      mode_q    <= 1'b0;
      stat_q    <= '0;
      ackseen_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        en_q   <= ctrl_wdata_i[NGRP-1:0];
        mode_q <= ctrl_wdata_i[MODE_BIT];
      end
      stat_q    <= set_ev | (stat_q & ~clr);
      ackseen_q <= ~set_ev & stat_q & ~clr & (ackseen_q | ack_i);
    end
  end

  assign dma_req_o = stat_q & en_q;

  always_comb begin
    ctrl_rdata_o = '0;
    ctrl_rdata_o[NGRP-1:0]          = en_q;
    ctrl_rdata_o[STAT_LSB +: NGRP]  = stat_q;
    ctrl_rdata_o[MODE_BIT]          = mode_q;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    p_set_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i[g] && en_q[g]) |=> stat_q[g]);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[g] && !(done_i[g] && en_q[g])) |=> !stat_q[g]);
    p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && stat_q[g] && src_req_i[g] && !w1c[g]) |=> stat_q[g]);
    p_pulse_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && ack_i[g] && !(done_i[g] && en_q[g])) |=> !stat_q[g]);
    p_w1c_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c[g] && !(done_i[g] && en_q[g])) |=> !stat_q[g]);
    p_disable_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[g] && !clr[g]) |=> ($stable(stat_q[g]) || $past(stat_q[g]) == 1'b0));
  end
endmodule

// File: tb/conv_dma_req_bench.sv
`timescale 1ns/1ps
module conv_dma_req_bench;
  localparam int NGRP = 8;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NGRP-1:0] done_i = '0, src_req_i = '0, ack_i = '0;
  logic            ctrl_we_i = 1'b0;
  logic [DW-1:0]   ctrl_wdata_i = '0;
  logic [DW-1:0]   ctrl_rdata_o;
  logic [NGRP-1:0] dma_req_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  conv_dma_req u_conv_dma_req (.*);

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [7:0] en, input logic mode, input logic [7:0] st);
    word = {2'b00, mode, 5'b0, st, 8'b0, en};
  endfunction

  task automatic wr(input logic [7:0] en, input logic mode, input logic [7:0] clrm);
    ctrl_we_i    = 1'b1;
    ctrl_wdata_i = word(en, mode, clrm);
    step();
    ctrl_we_i    = 1'b0;
    ctrl_wdata_i = '0;
  endtask

  task automatic pulse_done(input logic [7:0] m);
    done_i = m;
    step();
    done_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 control word", ctrl_rdata_o, 32'h0);
    chk("R1 requests", {24'h0, dma_req_o}, 32'h0);
  endtask

  task automatic t_set();
    wr(8'hFB, 1'b0, 8'hFF);
    pulse_done(8'h01);
    chk("R2 request after done", {24'h0, dma_req_o}, 32'h01);
    chk("R2 status after done", ctrl_rdata_o, word(8'hFB, 1'b0, 8'h01));
    pulse_done(8'h04);
    chk("R2 disabled group not set", ctrl_rdata_o, word(8'hFB, 1'b0, 8'h01));
    wr(8'hFF, 1'b0, 8'hFF);
  endtask

  task automatic t_latched();
    src_req_i = 8'h02;
    pulse_done(8'h02);
    chk("R3 pending", {24'h0, dma_req_o}, 32'h02);
    ack_i = 8'h02; step(); ack_i = '0;
    chk("R3 ack with source high holds", {24'h0, dma_req_o}, 32'h02);
    step(); step();
    chk("R3 still held while source high", {24'h0, dma_req_o}, 32'h02);
    src_req_i = '0; step();
    chk("R3 clears when source falls after ack", {24'h0, dma_req_o}, 32'h00);
    pulse_done(8'h02);
    step();
    chk("R3 source low without ack holds", {24'h0, dma_req_o}, 32'h02);
    ack_i = 8'h02; step(); ack_i = '0;
    chk("R3 ack with source low clears", {24'h0, dma_req_o}, 32'h00);
  endtask

  task automatic t_pulsed();
    wr(8'hFF, 1'b1, 8'h00);
    src_req_i = 8'h08;
    pulse_done(8'h08);
    chk("R4 pending", {24'h0, dma_req_o}, 32'h08);
    ack_i = 8'h08; step(); ack_i = '0;
    chk("R4 ack alone clears", {24'h0, dma_req_o}, 32'h00);
    src_req_i = '0;
  endtask

  task automatic t_w1c();
    wr(8'hFF, 1'b0, 8'h00);
    pulse_done(8'h41);
    wr(8'hFF, 1'b0, 8'h01);
    chk("R5 write one clears bit 16 only", ctrl_rdata_o, word(8'hFF, 1'b0, 8'h40));
    wr(8'h5A, 1'b1, 8'h00);
    chk("R5 zero write keeps status, stores enables and mode", ctrl_rdata_o, word(8'h5A, 1'b1, 8'h40));
    wr(8'hFF, 1'b0, 8'hFF);
    chk("R5 clear all", ctrl_rdata_o, word(8'hFF, 1'b0, 8'h00));
  endtask

  task automatic t_collide();
    pulse_done(8'h10);
    done_i = 8'h10; ctrl_we_i = 1'b1; ctrl_wdata_i = word(8'hFF, 1'b0, 8'h10);
    step();
    done_i = '0; ctrl_we_i = 1'b0; ctrl_wdata_i = '0;
    chk("R6 set beats write clear", {24'h0, dma_req_o}, 32'h10);
    wr(8'hFF, 1'b1, 8'h00);
    done_i = 8'h10; ack_i = 8'h10; step(); done_i = '0; ack_i = '0;
    chk("R6 set beats ack clear", {24'h0, dma_req_o}, 32'h10);
    wr(8'hFF, 1'b0, 8'hFF);
  endtask

  task automatic t_mask();
    pulse_done(8'h80);
    wr(8'h7F, 1'b0, 8'h00);
    chk("R7 disabled request masked", {24'h0, dma_req_o}, 32'h00);
    chk("R7 status kept", ctrl_rdata_o, word(8'h7F, 1'b0, 8'h80));
    wr(8'hFF, 1'b0, 8'h00);
    chk("R7 re-enable restores request", {24'h0, dma_req_o}, 32'h80);
    wr(8'hFF, 1'b0, 8'hFF);
  endtask

  task automatic t_indep();
    wr(8'hFF, 1'b1, 8'h00);
    pulse_done(8'h0F);
    ack_i = 8'h04; step(); ack_i = '0;
    chk("R8 ack touches only its group", {24'h0, dma_req_o}, 32'h0B);
    wr(8'hFF, 1'b1, 8'h02);
    chk("R8 write clear touches only its group", ctrl_rdata_o, word(8'hFF, 1'b1, 8'h09));
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_set();
    t_latched();
    t_pulsed();
    t_w1c();
    t_collide();
    t_mask();
    t_indep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule